// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a parallel NOR flash device, modelled synchronously. The host writes commands through chip-enable and write-enable strobes. The block decodes one-cycle and two-cycle command sequences and picks the source of read data: array data, identifier codes or a status byte. For erase and program it sends start pulses, with the target address and data, to an abstract internal engine. The engine reports back only through a busy input.

Erase and program can be suspended and resumed. The topmost block of the address space is a boot block. An erase or program aimed at it is refused unless the write-protect unlock input is high or the high-voltage reset unlock input is high. A refused or malformed sequence is reported in the status byte. Reads then return that status byte until the host writes a new mode command.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the read mode is array, all status error and suspend bits are 0, and no engine pulse is high.
- R2: A host write is taken when the strobes stop being both low. The value taken is the address and data present in the last cycle that both strobes were low. It does not matter whether chip-enable or write-enable rises first.
- R3: Command 0xFF selects array reads, where host_rdata equals array_rdata. Command 0x90 selects identifier reads, where host_addr bit 0 = 0 returns MFR_CODE and bit 0 = 1 returns DEV_CODE.
- R4: Command 0x70 selects status reads. The status byte is laid out as bit7 ready (= not eng_busy), bit6 suspended, bit5 erase error, bit4 program error, bit3 protect violation, and bits 2..0 read as zero.
- R5: Command 0x50 clears bits 5, 4 and 3 of the status byte and leaves the read mode unchanged.
- R6: Writing 0x20 and then 0xD0 raises eng_erase_go for exactly one cycle, with eng_addr equal to the confirm cycle's address. The read mode becomes status. At most one engine pulse is high in any cycle.
- R7: Writing 0x40 or 0x10 and then a second write raises eng_prog_go for one cycle, with eng_addr and eng_data taken from the second write. The read mode becomes status.
- R8: If the second write of an erase sequence is not 0xD0, status bits 5 and 4 are both set, no pulse is issued, and the read mode becomes status.
- R9: The boot block is the block whose upper BLK_W address bits are all ones. An erase or program aimed at it, with both wp_unlock and hv_unlock low, issues no pulse. It sets bit 3 together with bit 5 (erase) or bit 4 (program).
- R10: Command 0xB0, while eng_busy is high and nothing is suspended, raises eng_suspend_go and sets bit 6. Command 0xD0, while suspended, raises eng_resume_go and clears bit 6. Command 0xD0 with nothing suspended has no effect. Both commands make the read mode status.
- R11: An unlisted command code changes neither the read mode nor the status byte, and raises no pulse.
- R12: A setup code (0x20, 0x40, 0x10) written while eng_busy is high or an operation is suspended is ignored. The following write is then decoded as a fresh first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ce_n | input | 1 | Host chip-enable strobe, active low |
| host_we_n | input | 1 | Host write-enable strobe, active low |
| host_addr | input | AW | Host address for writes and reads |
| host_wdata | input | DW | Host write data / command code |
| host_rdata | output | DW | Read data selected by the current read mode |
| array_rdata | input | DW | Data from the memory array at host_addr |
| wp_unlock | input | 1 | Write-protect unlock for the boot block |
| hv_unlock | input | 1 | High-voltage reset level, also unlocks the boot block |
| eng_busy | input | 1 | Internal engine is running an operation |
| eng_erase_go | output | 1 | One-cycle block erase start |
| eng_prog_go | output | 1 | One-cycle program start |
| eng_suspend_go | output | 1 | One-cycle suspend request |
| eng_resume_go | output | 1 | One-cycle resume request |
| eng_addr | output | AW | Target address for erase/program |
| eng_data | output | DW | Data to program |

## Verification
Several rules are checked on every clock cycle: that engine pulses never overlap, that an erase pulse always follows a confirm written during a setup cycle, that no pulse reaches the boot block without an unlock, that a resume needs a prior suspend and a suspend sets the flag, and that a clear empties the error bits. Other behaviour can only be shown by the bench's scenarios. This covers which strobe ends a write, the identifier and array read values, the exact status byte after bad confirms and locked targets, and setup codes that are ignored while the engine is busy or suspended. The bench's reference model checks the read data and the pulses in every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_e;
  typedef enum logic [1:0] {CS_IDLE, CS_ERASE_ARM, CS_PROG_ARM} cstate_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

  typedef struct packed {
    logic ready;
    logic susp;
    logic eerr;
    logic perr;
    logic prot;
  } status_t;

  // status byte: ready, suspended, erase err, program err, protect, 3 zeros
  function automatic logic [7:0] pack_status(input status_t s);
    return {s.ready, s.susp, s.eerr, s.perr, s.prot, 3'b000};
  endfunction

  function automatic logic is_prog_setup(input logic [7:0] c);
    return (c == CMD_PROG_A) || (c == CMD_PROG_B);
  endfunction

  function automatic logic is_setup(input logic [7:0] c);
    return (c == CMD_ERASE) || is_prog_setup(c);
  endfunction

endpackage

// File: rtl/flash_strobe_capture.sv
module flash_strobe_capture #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          active;
  logic          act_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign active = ~ce_n & ~we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= active;
      if (active) begin
        addr_q <= addr;
        data_q <= data;
      end
    end
  end

  // first strobe to rise ends the write
  assign wr_evt  = act_q & ~active;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    eng_busy,
  input  logic    clr_err,
  input  logic    set_eerr,
  input  logic    set_perr,
  input  logic    set_prot,
  input  logic    set_susp,
  input  logic    clr_susp,
  output status_t sr
);
  logic susp_q, eerr_q, perr_q, prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      eerr_q <= 1'b0;
      perr_q <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      if (clr_err) begin
        eerr_q <= 1'b0;
        perr_q <= 1'b0;
        prot_q <= 1'b0;
      end else begin
        if (set_eerr) eerr_q <= 1'b1;
        if (set_perr) perr_q <= 1'b1;
        if (set_prot) prot_q <= 1'b1;
      end
      if (set_susp)      susp_q <= 1'b1;
      else if (clr_susp) susp_q <= 1'b0;
    end
  end

  always_comb begin
    sr.ready = ~eng_busy;
    sr.susp  = susp_q;
    sr.eerr  = eerr_q;
    sr.perr  = perr_q;
    sr.prot  = prot_q;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_busy,
  input  logic          unlock_ok,
  input  logic          suspended,
  output rmode_e        mode,
  output logic          in_setup,
  output logic          clr_err,
  output logic          set_eerr,
  output logic          set_perr,
  output logic          set_prot,
  output logic          set_susp,
  output logic          clr_susp,
  output logic          erase_go,
  output logic          prog_go,
  output logic          susp_go,
  output logic          res_go,
  output logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_data
);
  localparam logic [BW-1:0] BOOT_BLK = {BW{1'b1}};

  rmode_e        mode_q, mode_n;
  cstate_e       st_q, st_n;
  logic          erase_n, prog_n, susp_n, res_n;
  logic          erase_q, prog_q, susp_q, res_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [7:0]    cmd;
  logic          locked;

  assign cmd    = wr_data[7:0];
  assign locked = (wr_addr[AW-1 -: BW] == BOOT_BLK) && !unlock_ok;

  always_comb begin
    mode_n   = mode_q;
    st_n     = st_q;
    erase_n  = 1'b0;
    prog_n   = 1'b0;
    susp_n   = 1'b0;
    res_n    = 1'b0;
    clr_err  = 1'b0;
    set_eerr = 1'b0;
    set_perr = 1'b0;
    set_prot = 1'b0;
    set_susp = 1'b0;
    clr_susp = 1'b0;
    if (wr_evt) begin
      unique case (st_q)
        CS_ERASE_ARM: begin
          st_n   = CS_IDLE;
          mode_n = RM_STATUS;
          if (cmd != CMD_CONFIRM) begin
            set_eerr = 1'b1;
            set_perr = 1'b1;
          end else if (locked) begin
            set_eerr = 1'b1;
            set_prot = 1'b1;
          end else begin
            erase_n = 1'b1;
          end
        end
        CS_PROG_ARM: begin
          st_n   = CS_IDLE;
          mode_n = RM_STATUS;
          if (locked) begin
            set_perr = 1'b1;
            set_prot = 1'b1;
          end else begin
            prog_n = 1'b1;
          end
        end
        default: begin
          if (is_setup(cmd)) begin
            if (!eng_busy && !suspended) begin
              st_n   = (cmd == CMD_ERASE) ? CS_ERASE_ARM : CS_PROG_ARM;
              mode_n = RM_STATUS;
            end
          end else begin
            unique case (cmd)
              CMD_READ_ARRAY: mode_n = RM_ARRAY;
              CMD_IDENT:      mode_n = RM_IDENT;
              CMD_STATUS:     mode_n = RM_STATUS;
              CMD_CLEAR:      clr_err = 1'b1;
              CMD_SUSPEND: begin
                if (eng_busy && !suspended) begin
                  susp_n   = 1'b1;
                  set_susp = 1'b1;
                  mode_n   = RM_STATUS;
                end
              end
              CMD_CONFIRM: begin
                if (suspended) begin
                  res_n    = 1'b1;
                  clr_susp = 1'b1;
                  mode_n   = RM_STATUS;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= RM_ARRAY;
      st_q    <= CS_IDLE;
      erase_q <= 1'b0;
      prog_q  <= 1'b0;
      susp_q  <= 1'b0;
      res_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      mode_q  <= mode_n;
      st_q    <= st_n;
      erase_q <= erase_n;
      prog_q  <= prog_n;
      susp_q  <= susp_n;
      res_q   <= res_n;
      if (erase_n || prog_n) begin
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  assign mode     = mode_q;
  assign in_setup = (st_q == CS_ERASE_ARM);
  assign erase_go = erase_q;
  assign prog_go  = prog_q;
  assign susp_go  = susp_q;
  assign res_go   = res_q;
  assign eng_addr = addr_q;
  assign eng_data = data_q;
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] MFR_CODE = 8'hB0,
  parameter logic [DW-1:0] DEV_CODE = 8'h4B
) (
  input  rmode_e        mode,
  input  logic          id_sel,
  input  logic [DW-1:0] array_rdata,
  input  logic [7:0]    status_byte,
  output logic [DW-1:0] rdata
);
  always_comb begin
    unique case (mode)
      RM_IDENT:  rdata = id_sel ? DEV_CODE : MFR_CODE;
      RM_STATUS: rdata = DW'(status_byte);
      default:   rdata = array_rdata;
    endcase
  end
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int            AW       = 12,
  parameter int            DW       = 8,
  parameter int            BLK_W    = 3,
  parameter logic [DW-1:0] MFR_CODE = 8'hB0,
  parameter logic [DW-1:0] DEV_CODE = 8'h4B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_ce_n,
  input  logic          host_we_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [DW-1:0] array_rdata,
  input  logic          wp_unlock,
  input  logic          hv_unlock,
  input  logic          eng_busy,
  output logic          eng_erase_go,
  output logic          eng_prog_go,
  output logic          eng_suspend_go,
  output logic          eng_resume_go,
  output logic [AW-1:0] eng_addr,
  output logic [DW-1:0] eng_data
);
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  rmode_e        mode;
  logic          in_setup;
  logic          clr_err, set_eerr, set_perr, set_prot, set_susp, clr_susp;
  status_t       sr;
  logic [7:0]    status_byte;

  flash_strobe_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(host_ce_n), .we_n(host_we_n),
    .addr(host_addr), .data(host_wdata),
    .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_cmd_decoder #(.AW(AW), .DW(DW), .BW(BLK_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_busy(eng_busy),
    .unlock_ok(wp_unlock | hv_unlock), .suspended(sr.susp),
    .mode(mode), .in_setup(in_setup),
    .clr_err(clr_err), .set_eerr(set_eerr), .set_perr(set_perr),
    .set_prot(set_prot), .set_susp(set_susp), .clr_susp(clr_susp),
    .erase_go(eng_erase_go), .prog_go(eng_prog_go),
    .susp_go(eng_suspend_go), .res_go(eng_resume_go),
    .eng_addr(eng_addr), .eng_data(eng_data)
  );

  flash_status_reg u_sr (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
    .clr_err(clr_err), .set_eerr(set_eerr), .set_perr(set_perr),
    .set_prot(set_prot), .set_susp(set_susp), .clr_susp(clr_susp),
    .sr(sr)
  );

  assign status_byte = pack_status(sr);

  flash_read_mux #(.DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
    .mode(mode), .id_sel(host_addr[0]), .array_rdata(array_rdata),
    .status_byte(status_byte), .rdata(host_rdata)
  );
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_evt,
  input logic [7:0]    wr_cmd,
  input logic          in_setup,
  input logic          sr_susp,
  input logic [2:0]    sr_err,
  input logic          eng_busy,
  input logic          erase_go,
  input logic          prog_go,
  input logic          susp_go,
  input logic          res_go,
  input logic [BW-1:0] eng_blk,
  input logic          wp_unlock,
  input logic          hv_unlock
);
  p_single_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_go, prog_go, susp_go, res_go}));

  p_erase_confirm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> $past(wr_evt && in_setup && wr_cmd == 8'hD0));

  p_boot_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((erase_go || prog_go) && eng_blk == {BW{1'b1}}) |-> $past(wp_unlock || hv_unlock));

  p_resume_needs_susp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_go |-> ($past(sr_susp) && !sr_susp));

  p_suspend_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    susp_go |-> (sr_susp && $past(eng_busy)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !in_setup && wr_cmd == 8'h50) |=> (sr_err == 3'b000));
endmodule

bind flash_cmd_front flash_cmd_checker #(.BW(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_cmd(wr_data[7:0]),
  .in_setup(in_setup), .sr_susp(sr.susp),
  .sr_err({sr.eerr, sr.perr, sr.prot}), .eng_busy(eng_busy),
  .erase_go(eng_erase_go), .prog_go(eng_prog_go),
  .susp_go(eng_suspend_go), .res_go(eng_resume_go),
  .eng_blk(eng_addr[AW-1 -: BLK_W]),
  .wp_unlock(wp_unlock), .hv_unlock(hv_unlock)
);

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  arr;
  logic        wp = 1'b0, hv = 1'b0, busy = 1'b0;
  logic        e_go, p_go, s_go, r_go;
  logic [11:0] e_addr;
  logic [7:0]  e_data;

  int n_run = 0, n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;

  // reference model state
  int          m_mode = 0;   // 0 array, 1 ident, 2 status
  int          m_arm = 0;    // 0 none, 1 erase armed, 2 program armed
  bit          m_susp = 0, m_eerr = 0, m_perr = 0, m_prot = 0;
  bit          x_e = 0, x_p = 0, x_s = 0, x_r = 0;
  logic [11:0] x_addr = '0;
  logic [7:0]  x_data = '0;

  always #10 clk = ~clk;

  assign arr = addr[7:0] ^ 8'hA5;

  flash_cmd_front u0 (
    .clk(clk), .rst_n(rst_n), .host_ce_n(ce_n), .host_we_n(we_n),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .array_rdata(arr), .wp_unlock(wp), .hv_unlock(hv), .eng_busy(busy),
    .eng_erase_go(e_go), .eng_prog_go(p_go), .eng_suspend_go(s_go),
    .eng_resume_go(r_go), .eng_addr(e_addr), .eng_data(e_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    logic [7:0] v = 8'h00;
    if (!busy)  v = v + 8'h80;
    if (m_susp) v = v + 8'h40;
    if (m_eerr) v = v + 8'h20;
    if (m_perr) v = v + 8'h10;
    if (m_prot) v = v + 8'h08;
    return v;
  endfunction

  function automatic logic [7:0] m_read();
    if (m_mode == 1) return addr[0] ? 8'h4B : 8'hB0;
    if (m_mode == 2) return m_status();
    return arr;
  endfunction

  function automatic bit in_boot(input logic [11:0] a);
    return a >= 12'hE00;
  endfunction

  task automatic model_apply(input logic [11:0] a, input logic [7:0] d);
    if (m_arm == 1) begin
      m_arm = 0; m_mode = 2;
      if (d != 8'hD0) begin m_eerr = 1; m_perr = 1; end
      else if (in_boot(a) && !wp && !hv) begin m_eerr = 1; m_prot = 1; end
      else begin x_e = 1; x_addr = a; x_data = d; end
    end else if (m_arm == 2) begin
      m_arm = 0; m_mode = 2;
      if (in_boot(a) && !wp && !hv) begin m_perr = 1; m_prot = 1; end
      else begin x_p = 1; x_addr = a; x_data = d; end
    end else if (d == 8'h20 || d == 8'h40 || d == 8'h10) begin
      if (!busy && !m_susp) begin m_arm = (d == 8'h20) ? 1 : 2; m_mode = 2; end
    end else if (d == 8'hFF) m_mode = 0;
    else if (d == 8'h90) m_mode = 1;
    else if (d == 8'h70) m_mode = 2;
    else if (d == 8'h50) begin m_eerr = 0; m_perr = 0; m_prot = 0; end
    else if (d == 8'hB0) begin
      if (busy && !m_susp) begin m_susp = 1; x_s = 1; m_mode = 2; end
    end else if (d == 8'hD0) begin
      if (m_susp) begin m_susp = 0; x_r = 1; m_mode = 2; end
    end
  endtask

  // one host write; rel_ce selects which strobe rises first (R2)
  task automatic wr(input logic [11:0] a, input logic [7:0] d, input bit rel_ce);
    @(posedge clk); #5; ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(posedge clk); #5; if (rel_ce) ce_n = 1'b1; else we_n = 1'b1;
    addr = ~a; wdata = ~d;
    @(posedge clk); #1; model_apply(a, d);
    @(posedge clk); #1; x_e = 0; x_p = 0; x_s = 0; x_r = 0;
    #4; ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd_at(input string tag, input logic [11:0] a, input logic [7:0] exp);
    @(posedge clk); #5; addr = a;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic set_busy(input bit b);
    @(posedge clk); #5; busy = b;
  endtask

  // reference compare on every cycle
  always @(negedge clk) begin
    if (cmp_on) begin
      chk((m_mode == 2) ? "R4 status read" : "R3 read data", rdata, m_read());
      chk("R6 erase pulse", e_go, x_e);
      chk("R7 program pulse", p_go, x_p);
      chk("R10 suspend pulse", s_go, x_s);
      chk("R10 resume pulse", r_go, x_r);
      if (x_e || x_p) begin
        chk(x_e ? "R6 erase addr" : "R7 prog addr", e_addr, x_addr);
        if (x_p) chk("R7 prog data", e_data, x_data);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 array read after reset", rdata, arr);
    chk("R1 no pulses after reset", {e_go, p_go, s_go, r_go}, 4'b0000);
    cmp_on = 1;
    wr(12'h000, 8'h70, 0);
    rd_at("R1 status after reset", 12'h000, 8'h80);

    // R3 identifier and array
    wr(12'h123, 8'h90, 1);
    rd_at("R3 manufacturer code", 12'h010, 8'hB0);
    rd_at("R3 device code", 12'h011, 8'h4B);
    // R11 reserved code in ident mode
    wr(12'h000, 8'h33, 0);
    rd_at("R11 reserved keeps ident", 12'h011, 8'h4B);
    wr(12'h000, 8'hFF, 0);
    rd_at("R3 array after FF", 12'h05C, 8'h5C ^ 8'hA5);
    // R10 resume with nothing suspended is ignored
    wr(12'h000, 8'hD0, 0);
    rd_at("R10 lone D0 ignored", 12'h05C, 8'h5C ^ 8'hA5);

    // R7 program, both setup codes, both strobe orders (R2)
    wr(12'h000, 8'h40, 0);
    wr(12'h234, 8'h3C, 1);
    rd_at("R7 status after program", 12'h000, 8'h80);
    wr(12'h000, 8'h10, 1);
    wr(12'h1F0, 8'hC3, 0);

    // R6 erase
    wr(12'h000, 8'h20, 0);
    wr(12'h4A0, 8'hD0, 0);
    rd_at("R6 status after erase", 12'h000, 8'h80);

    // R8 bad confirm
    wr(12'h000, 8'h20, 0);
    wr(12'h4A0, 8'h55, 1);
    rd_at("R8 bad confirm status", 12'h000, 8'hB0);
    // R5 clear keeps status mode
    wr(12'h000, 8'h50, 0);
    rd_at("R5 cleared status", 12'h000, 8'h80);

    // R9 boot block locked
    wr(12'h000, 8'h40, 0);
    wr(12'hE10, 8'h99, 0);
    rd_at("R9 locked program", 12'h000, 8'h98);
    wr(12'h000, 8'h50, 0);
    wr(12'h000, 8'h20, 0);
    wr(12'hFFF, 8'hD0, 0);
    rd_at("R9 locked erase", 12'h000, 8'hA8);
    wr(12'h000, 8'h50, 0);
    wp = 1'b1;
    wr(12'h000, 8'h40, 0);
    wr(12'hE10, 8'h99, 0);
    rd_at("R9 unlocked program", 12'h000, 8'h80);
    wp = 1'b0; hv = 1'b1;
    wr(12'h000, 8'h20, 0);
    wr(12'hF00, 8'hD0, 1);
    rd_at("R9 hv unlocked erase", 12'h000, 8'h80);
    hv = 1'b0;

    // R10 suspend/resume, R12 setup while busy/suspended
    set_busy(1);
    wr(12'h000, 8'h40, 0);
    wr(12'h000, 8'h77, 0);
    rd_at("R12 setup ignored while busy", 12'h000, 8'h00);
    wr(12'h000, 8'hB0, 0);
    set_busy(0);
    rd_at("R10 suspended status", 12'h000, 8'hC0);
    wr(12'h000, 8'h20, 0);
    wr(12'h000, 8'hFF, 0);
    rd_at("R12 setup ignored while suspended", 12'h066, 8'h66 ^ 8'hA5);
    wr(12'h000, 8'hD0, 0);
    set_busy(1);
    rd_at("R10 resumed status", 12'h000, 8'h00);
    wr(12'h000, 8'hB0, 1);
    rd_at("R10 second suspend", 12'h000, 8'h40);
    wr(12'h000, 8'hD0, 1);
    set_busy(0);
    rd_at("R10 final status", 12'h000, 8'h80);

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule